// File: doc/BRIEF.md
# Dual-Mode Pseudo-Random Noise Generator

This block turns a fixed-rate system clock into a stream of pseudo-random on/off decisions that gate an externally supplied 4-bit volume. A 15-bit feedback shift register advances once every time a down-counting rate timer expires. The timer's spacing comes from a built-in 16-entry table of periods, and a 4-bit index written through a single control byte picks the entry. The same control byte carries a mode flag that moves the second feedback tap. The long mode gives a sequence that repeats after 32767 steps. The short mode gives a metallic sequence that repeats after 93 steps.

The gated result leaves the block as `vol_out`. It is silent whenever the register's lowest bit is high or the caller signals that its length counter has run out. Envelope shaping, length counting and mixing are done outside the block. Their results arrive through `vol_in` and `len_zero`.

Top module: `noise_lfsr_gen`

## Requirements
- R1: After reset the shift register holds 1, the timer count is 0, the mode flag is clear and the period index is 0. With the register holding 1, `vol_out` is 0.
- R2: With the mode flag clear, each step computes feedback as register bit 0 XOR register bit 1.
- R3: With the mode flag set, each step computes feedback as register bit 0 XOR register bit 6.
- R4: A step moves the register right by one place and drops bit 0. Bit 14 takes the feedback value. Between steps the register does not change.
- R5: The timer steps when its count is 0 and reloads the table period minus 1. Otherwise it decrements by 1. Index values 0x0 through 0xF give periods 4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034 and 4068 clocks.
- R6: A control write with `cfg_we` high stores bit 7 as the mode flag and bits 3:0 as the period index. Bits 6:4 have no effect.
- R7: A write does not restart the timer. A new index is used at the next reload only.
- R8: `vol_out` is 0 when register bit 0 is 1 or `len_zero` is high. Otherwise it equals `vol_in`.
- R9: With the mode flag set, the sequence of bit-0 values seen after successive steps repeats every 93 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_data | input | 8 | Control byte: bit 7 mode flag, bits 3:0 period index |
| vol_in | input | 4 | Volume to be gated |
| len_zero | input | 1 | High when the external length counter is exhausted |
| vol_out | output | 4 | Gated volume |

## Verification
The register's contents can only be seen one bit at a time, through the gated volume. The hardest case to reach from the ports is a period change that lands in the middle of a long countdown. The bench selects the 4068-clock period, waits partway into the count, and then writes a short index. It then shows that the next step still falls on the old schedule and that the faster spacing begins only after that step. The short-mode cycle length is shown by recording bit 0 after each of about 200 steps. The bench then checks that the record repeats at distance 93 and does not repeat at distances 3 or 31.

// File: rtl/noise_pkg.sv
package noise_pkg;

  localparam int PERIOD_W = 12;
  localparam int IDX_W    = 4;

  // Rate table: step spacing in input clocks for each index.
  function automatic logic [PERIOD_W-1:0] noise_period(input logic [IDX_W-1:0] idx);
    logic [PERIOD_W-1:0] p;
    case (idx)
      4'h0: p = 12'd4;
      4'h1: p = 12'd8;
      4'h2: p = 12'd16;
      4'h3: p = 12'd32;
      4'h4: p = 12'd64;
      4'h5: p = 12'd96;
      4'h6: p = 12'd128;
      4'h7: p = 12'd160;
      4'h8: p = 12'd202;
      4'h9: p = 12'd254;
      4'hA: p = 12'd380;
      4'hB: p = 12'd508;
      4'hC: p = 12'd762;
      4'hD: p = 12'd1016;
      4'hE: p = 12'd2034;
      default: p = 12'd4068;
    endcase
    return p;
  endfunction

  // Value loaded into the down counter so that spacing equals the table entry.
  function automatic logic [PERIOD_W-1:0] noise_reload(input logic [IDX_W-1:0] idx);
    return noise_period(idx) - 1'b1;
  endfunction

endpackage

// File: rtl/noise_rate_timer.sv
module noise_rate_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload,
  output logic             step,
  output logic [CNT_W-1:0] cnt
);

  assign step = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= reload;
    else           cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/noise_shift_reg.sv
module noise_shift_reg #(
  parameter int W         = 15,
  parameter int TAP_LONG  = 1,
  parameter int TAP_SHORT = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         mode,
  output logic [W-1:0] state
);

  localparam logic [W-1:0] SEED = {{(W-1){1'b0}}, 1'b1};

  logic fb;
  assign fb = state[0] ^ (mode ? state[TAP_SHORT] : state[TAP_LONG]);

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= {fb, state[W-1:1]};
  end

endmodule

// File: rtl/noise_gate.sv
module noise_gate #(
  parameter int VOL_W = 4
) (
  input  logic             noise_bit,
  input  logic             len_zero,
  input  logic [VOL_W-1:0] vol_in,
  output logic [VOL_W-1:0] vol_out
);

  assign vol_out = (noise_bit || len_zero) ? '0 : vol_in;

endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
  import noise_pkg::*;
#(
  parameter int VOL_W     = 4,
  parameter int LFSR_W    = 15,
  parameter int CFG_W     = 8,
  parameter int MODE_BIT  = 7,
  parameter int TAP_LONG  = 1,
  parameter int TAP_SHORT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic [VOL_W-1:0] vol_in,
  input  logic             len_zero,
  output logic [VOL_W-1:0] vol_out
);

  localparam int CNT_W = PERIOD_W;

  logic             mode_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] reload_w;
  logic [CNT_W-1:0] cnt_w;
  logic             step_w;
  logic [LFSR_W-1:0] lfsr_w;
  logic             cfg_unused;

  assign cfg_unused = ^cfg_data[MODE_BIT-1:IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      idx_q  <= '0;
    end else if (cfg_we) begin
      mode_q <= cfg_data[MODE_BIT];
      idx_q  <= cfg_data[IDX_W-1:0];
    end
  end

  assign reload_w = noise_reload(idx_q);

  noise_rate_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (reload_w),
    .step   (step_w),
    .cnt    (cnt_w)
  );

  noise_shift_reg #(.W(LFSR_W), .TAP_LONG(TAP_LONG), .TAP_SHORT(TAP_SHORT)) u_sreg (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step_w),
    .mode  (mode_q),
    .state (lfsr_w)
  );

  noise_gate #(.VOL_W(VOL_W)) u_gate (
    .noise_bit (lfsr_w[0]),
    .len_zero  (len_zero),
    .vol_in    (vol_in),
    .vol_out   (vol_out)
  );

endmodule

// File: rtl/noise_lfsr_gen_chk.sv
module noise_lfsr_gen_chk #(
  parameter int VOL_W     = 4,
  parameter int LFSR_W    = 15,
  parameter int CNT_W     = 12,
  parameter int TAP_LONG  = 1,
  parameter int TAP_SHORT = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic [CNT_W-1:0]  cnt,
  input logic [LFSR_W-1:0] lfsr,
  input logic              mode,
  input logic              len_zero,
  input logic [VOL_W-1:0]  vol_out
);

  // R1: the register can never reach the all-zero lock-up state
  p_never_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  // R2: long-mode feedback lands in the top bit
  p_fb_long_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !mode) |=> lfsr[LFSR_W-1] == $past(lfsr[0] ^ lfsr[TAP_LONG]));

  // R3: short-mode feedback lands in the top bit
  p_fb_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode) |=> lfsr[LFSR_W-1] == $past(lfsr[0] ^ lfsr[TAP_SHORT]));

  // R4: a step moves every bit one place right
  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> lfsr[LFSR_W-2:0] == $past(lfsr[LFSR_W-1:1]));

  // R4: no step, no change
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(lfsr));

  // R5: between steps the timer counts down by one
  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> cnt == $past(cnt) - 1'b1);

  // R5: after a step the reload never lands on zero (minimum period 4)
  p_reload_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);

  // R8: a high noise bit or an exhausted length silences the output
  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lfsr[0] || len_zero) |-> vol_out == '0);

endmodule

bind noise_lfsr_gen noise_lfsr_gen_chk #(
  .VOL_W(VOL_W), .LFSR_W(LFSR_W), .CNT_W(CNT_W),
  .TAP_LONG(TAP_LONG), .TAP_SHORT(TAP_SHORT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step     (step_w),
  .cnt      (cnt_w),
  .lfsr     (lfsr_w),
  .mode     (mode_q),
  .len_zero (len_zero),
  .vol_out  (vol_out)
);

// File: tb/sim_noise_lfsr_gen.sv
`timescale 1ns/1ps
module sim_noise_lfsr_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic [3:0] vol_in = 4'hF;
  logic       len_zero = 1'b0;
  logic [3:0] vol_out;

  always #2.5 clk = ~clk;

  noise_lfsr_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .vol_in(vol_in), .len_zero(len_zero), .vol_out(vol_out)
  );

  int ptab[16] = '{4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068};

  // Behavioural reference
  int  m_lfsr, m_cnt, m_idx, n_checks, n_fail, cycles, m_steps;
  bit  m_mode, m_stepped, collect;
  bit  bits_q[$];
  string cur_req = "R1";

  always @(posedge clk) begin
    cycles++;
    m_stepped = 1'b0;
    if (!rst_n) begin
      m_lfsr = 1; m_cnt = 0; m_mode = 0; m_idx = 0;
    end else begin
      if (m_cnt == 0) begin
        int fb;
        fb = (m_lfsr ^ (m_lfsr >> (m_mode ? 6 : 1))) & 1;
        m_lfsr = (m_lfsr >> 1) | (fb << 14);
        m_cnt = ptab[m_idx] - 1;
        m_stepped = 1'b1;
        m_steps++;
      end else begin
        m_cnt--;
      end
      if (cfg_we) begin
        m_mode = cfg_data[7];
        m_idx = int'(cfg_data[3:0]);
      end
    end
  end

  function automatic logic [3:0] expect_vol();
    return (((m_lfsr & 1) != 0) || len_zero) ? 4'h0 : vol_in;
  endfunction

  task automatic check(input string req, input logic [3:0] exp_v);
    n_checks++;
    if (vol_out !== exp_v) begin
      n_fail++;
      $display("FAIL %s: vol_out=%h expected=%h at cycle %0d", req, vol_out, exp_v, cycles);
    end
  endtask

  // Advance one cycle: wait for negedge, compare, push collected bit
  task automatic tick();
    @(negedge clk);
    check(cur_req, expect_vol());
    if (collect && m_stepped) bits_q.push_back(vol_out == 4'h0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_data = v; cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected end before %0d cycles", 150000);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: register holds 1 during reset so the output is silent
    n_checks++;
    if (vol_out !== 4'h0) begin
      n_fail++;
      $display("FAIL R1: reset vol_out=%h expected=0", vol_out);
    end
    // R2 R4: long mode, fastest rate
    cur_req = "R2 R4";
    run(400);
    // R8: length-zero and volume patterns
    cur_req = "R8";
    for (int i = 0; i < 120; i++) begin
      len_zero = (i % 7) < 2;
      vol_in = 4'(i * 5 + 3);
      tick();
    end
    len_zero = 1'b0; vol_in = 4'hF;
    // R5: every period index
    cur_req = "R5";
    for (int k = 0; k < 16; k++) begin
      write_cfg(8'(k));
      run(2 * ptab[k] + 9);
    end
    // R7: slowest period, then switch mid-count to the fastest
    cur_req = "R7";
    write_cfg(8'h0F);
    run(4068 + 1500);
    write_cfg(8'h00);
    run(2700);
    // R6: junk in bits 6:4 changes nothing
    cur_req = "R6";
    write_cfg(8'h71);
    run(100);
    write_cfg(8'h72);
    run(150);
    // R3 R9: short mode, fastest rate, record bit 0 after each step
    cur_req = "R3";
    write_cfg(8'hF0);
    run(8);
    collect = 1'b1;
    run(4 * 200 + 4);
    collect = 1'b0;
    begin
      bit per93 = 1'b1, diff31 = 1'b0, diff3 = 1'b0;
      for (int i = 0; i + 93 < bits_q.size(); i++)
        if (bits_q[i] != bits_q[i + 93]) per93 = 1'b0;
      for (int i = 0; i + 31 < bits_q.size(); i++)
        if (bits_q[i] != bits_q[i + 31]) diff31 = 1'b1;
      for (int i = 0; i + 3 < bits_q.size(); i++)
        if (bits_q[i] != bits_q[i + 3]) diff3 = 1'b1;
      n_checks++;
      if (!(per93 && diff31 && diff3) || bits_q.size() < 190) begin
        n_fail++;
        $display("FAIL R9: repeat93=%0b differs31=%0b differs3=%0b samples=%0d expected 1 1 1 >=190",
                 per93, diff31, diff3, bits_q.size());
      end
    end
    // R1: reset mid-run returns to the seed
    cur_req = "R1";
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    cur_req = "R2 R4";
    run(200);
    summary();
  end

endmodule